// File: doc/BRIEF.md
# Random Number Generator Register Interface

This block sits between a single-bit noise input and a small register bank on the system bus. It gives software a stream of 32-bit random words. Noise is sampled in its own generator clock domain. It starts only after a short warm-up once generation is switched on. Each sampled bit crosses into the bus clock domain through a toggle handshake.

On the bus side, every arriving bit passes through a 16-bit linear feedback shift register and a 16-bit post-processing shift register. The result is packed into a 32-bit word. The first bits after start-up only prime the two shift registers. After that, every 32 new bits give a word, and the word is presented through the data register. Reading the data register consumes the word, and collection of the next word starts on its own.

Two health conditions are reported. A seed error means the noise appears stuck. A clock error means the generator clock appears to have stopped. Either condition, or a ready word, can raise an interrupt when interrupts are enabled.

Top module: `rng_regif`

## Requirements
- R1: After reset the control, status and data registers all read zero and `irq` is low.
- R2: Register address 0 is control. Bit 0 is `run` (generation on) and bit 1 is `irqEn`. Both bits read back as written, and all other bits read zero.
- R3: After `run` is set, the generator side waits 4 generator clock cycles, counted once `run` has been seen in that domain, before it samples the noise input for the first time. The data-ready flag cannot be set within the first 10 bus cycles after `run` is set.
- R4: Each bit `b` delivered to the bus side is processed as follows, using the old register values:
  - `fb` = `lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]`
  - `n` = `b^fb`
  - `out` = `post[15]^n`
  - `lfsr` becomes `{lfsr[14:0],n}`
  - `post` becomes `{post[14:0],lfsr[15]}`
  - the word register becomes `{word[30:0],out}`

  All of this state is zero when `run` is set. The first 32 bits only prime the registers. The word is loaded into the data register after 32 more bits.
- R5: Register address 1 is status. Bit 0 is data-ready, bit 1 is clock-error and bit 2 is seed-error.
- R6: A read of register address 2 (data) returns the stored word while data-ready is 1, and returns all zeros while it is 0.
- R7: A data read clears data-ready. Collection then restarts without further action, and data-ready sets again only after 32 new processed bits.
- R8: Seed-error sets when 64 consecutive delivered bits are equal. It is reported once per run of equal bits. Writing status with bit 2 at 0 clears it; writing 1 has no effect.
- R9: Clock-error sets when `run` is 1 and no generator clock edge has been seen for 32 bus cycles. It never sets while `run` is 0. Writing status with bit 1 at 0 clears it.
- R10: `irq` equals `irqEn` AND (data-ready OR clock-error OR seed-error).
- R11: Clearing `run` discards the stored word, the data-ready flag and all processing state.
- R12: The generator side holds each sampled bit unchanged until the bus side has acknowledged it, so every delivered bit equals the value that was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock: registers and post-processing |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| genClk | input | 1 | Generator clock for noise sampling |
| genRstN | input | 1 | Active-low asynchronous reset, generator domain |
| noiseIn | input | 1 | Single-bit noise source |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a read at address 2 consumes the word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is a known data word. Which noise samples get through the clock crossing depends on the handshake timing, so a varying noise stream gives no predictable word. The stimulus therefore holds the noise input at a constant 1, and then at a constant 0. Every delivered bit is then known regardless of timing, which makes the first word after start-up exactly computable and also drives the 64-equal-bit seed condition at the same moment. The clock-error path is reached by gating the generator clock off while `run` is set, and then again while it is clear.

// File: rtl/rng_pkg.sv
package rng_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } regAddrE;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;  // run is off: drop all processing state
    logic take;   // data register read this cycle
  } dpStrobeS;
endpackage

// File: rtl/rng_sampler.sv
module rng_sampler #(
  parameter int WARM = 4,
  parameter int SYNC = 2
) (
  input  logic busClk,
  input  logic busRstN,
  input  logic genClk,
  input  logic genRstN,
  input  logic runBus,
  input  logic noiseIn,
  output logic bitValid,
  output logic bitVal,
  output logic beatEdge
);
  localparam int WCW = $clog2(WARM + 1);
  localparam logic [WCW-1:0] WARM_END = WCW'(WARM);

  // generator domain
  logic [SYNC-1:0] runPipe, ackPipe;
  logic [WCW-1:0]  warmCnt;
  logic reqTog, bitHold, beatTog, ackTog;
  logic runGen, ackGen, warmDone, canSample;

  assign runGen    = runPipe[SYNC-1];
  assign ackGen    = ackPipe[SYNC-1];
  assign warmDone  = (warmCnt == WARM_END);
  assign canSample = runGen && warmDone && (ackGen == reqTog);

  always_ff @(posedge genClk or negedge genRstN) begin
    if (!genRstN) begin
      runPipe <= '0;
      ackPipe <= '0;
      warmCnt <= '0;
      reqTog  <= 1'b0;
      bitHold <= 1'b0;
      beatTog <= 1'b0;
    end else begin
      runPipe <= {runPipe[SYNC-2:0], runBus};
      ackPipe <= {ackPipe[SYNC-2:0], ackTog};
      beatTog <= ~beatTog;
      if (!runGen)        warmCnt <= '0;
      else if (!warmDone) warmCnt <= warmCnt + 1'b1;
      if (canSample) begin
        bitHold <= noiseIn;
        reqTog  <= ~reqTog;
      end
    end
  end

  // bus domain
  logic [SYNC-1:0] reqPipe, beatPipe;
  logic reqSeen, beatSeen;

  assign ackTog   = reqSeen;
  assign beatEdge = beatPipe[SYNC-1] != beatSeen;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqPipe  <= '0;
      beatPipe <= '0;
      reqSeen  <= 1'b0;
      beatSeen <= 1'b0;
      bitValid <= 1'b0;
      bitVal   <= 1'b0;
    end else begin
      reqPipe  <= {reqPipe[SYNC-2:0], reqTog};
      beatPipe <= {beatPipe[SYNC-2:0], beatTog};
      beatSeen <= beatPipe[SYNC-1];
      reqSeen  <= reqPipe[SYNC-1];
      bitValid <= reqPipe[SYNC-1] != reqSeen;
      if (reqPipe[SYNC-1] != reqSeen) bitVal <= bitHold;
    end
  end

  // R3: first sample only after the warm-up count completes
  a_r3_warm_before_sample: assert property (@(posedge genClk) disable iff (!genRstN)
    (reqTog != $past(reqTog)) |-> ($past(warmCnt) == WARM_END));

  // R12: sampled bit held while a request is outstanding
  a_r12_hold_until_ack: assert property (@(posedge genClk) disable iff (!genRstN)
    (reqTog != ackGen) |=> $stable(bitHold));

  // R12: each crossing yields a single delivery pulse
  a_r12_single_pulse: assert property (@(posedge busClk) disable iff (!busRstN)
    bitValid |=> !bitValid);
endmodule

// File: rtl/rng_datapath.sv
module rng_datapath
  import rng_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int FILL     = 32,
  parameter int SEED_RUN = 64
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              bitValid,
  input  logic              bitVal,
  input  dpStrobeS          stb,
  output logic              ready,
  output logic [WORD_W-1:0] dataWord,
  output logic              seedHit
);
  localparam int FCW = $clog2(FILL + 1);
  localparam int NCW = $clog2(WORD_W + 1);
  localparam int SCW = $clog2(SEED_RUN + 1);
  localparam logic [FCW-1:0] FILL_END  = FCW'(FILL);
  localparam logic [NCW-1:0] WORD_FULL = NCW'(WORD_W);
  localparam logic [SCW-1:0] SEED_MAX  = SCW'(SEED_RUN);
  localparam logic [SCW-1:0] SEED_LAST = SCW'(SEED_RUN - 1);

  logic [LFSR_W-1:0] lfsr, post;
  logic [WORD_W-1:0] shiftWord, hold;
  logic [FCW-1:0]    fillCnt;
  logic [NCW-1:0]    newBits;
  logic [SCW-1:0]    seedCnt;
  logic prevBit, fb, nb, outBit, filled, sameRun;

  assign fb       = ^(lfsr & TAPS);
  assign nb       = bitVal ^ fb;
  assign outBit   = post[LFSR_W-1] ^ nb;
  assign filled   = (fillCnt == FILL_END);
  assign sameRun  = (seedCnt != '0) && (bitVal == prevBit);
  assign seedHit  = bitValid && sameRun && (seedCnt == SEED_LAST);
  assign dataWord = hold;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      lfsr <= '0; post <= '0; shiftWord <= '0; hold <= '0;
      fillCnt <= '0; newBits <= '0; seedCnt <= '0;
      prevBit <= 1'b0; ready <= 1'b0;
    end else if (stb.flush) begin
      lfsr <= '0; post <= '0; shiftWord <= '0; hold <= '0;
      fillCnt <= '0; newBits <= '0; seedCnt <= '0;
      prevBit <= 1'b0; ready <= 1'b0;
    end else begin
      if (bitValid) begin
        lfsr      <= {lfsr[LFSR_W-2:0], nb};
        post      <= {post[LFSR_W-2:0], lfsr[LFSR_W-1]};
        shiftWord <= {shiftWord[WORD_W-2:0], outBit};
        prevBit   <= bitVal;
        if (!sameRun)                 seedCnt <= SCW'(1);
        else if (seedCnt != SEED_MAX) seedCnt <= seedCnt + 1'b1;
        if (!filled)                  fillCnt <= fillCnt + 1'b1;
        else if (newBits != WORD_FULL) newBits <= newBits + 1'b1;
      end
      if (stb.take) begin
        ready   <= 1'b0;
        newBits <= '0;
      end else if (!ready && newBits == WORD_FULL) begin
        ready   <= 1'b1;
        hold    <= shiftWord;
        newBits <= '0;
      end
    end
  end

  // R7: a word appears only after a full set of new bits
  a_r7_ready_after_full: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(ready) |-> ($past(newBits) == WORD_FULL));

  // R7 / R11: ready drops only on a data read or a stop
  a_r7_ready_drop_cause: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(ready) |-> $past(stb.take || stb.flush));

  // R4: no word while the registers are still priming
  a_r4_no_word_in_fill: assert property (@(posedge busClk) disable iff (!busRstN)
    !filled |-> !ready);
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CLK_LIMIT = 32
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              ready,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              seedHit,
  input  logic              beatEdge,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq,
  output logic              runOut,
  output dpStrobeS          stb
);
  localparam int ICW = $clog2(CLK_LIMIT + 1);
  localparam logic [ICW-1:0] IDLE_MAX = ICW'(CLK_LIMIT);

  logic runBit, irqEnBit, seedErr, clkErr;
  logic [ICW-1:0] idleCnt;
  regAddrE addrE;

  assign addrE     = regAddrE'(regAddr);
  assign runOut    = runBit;
  assign stb.flush = !runBit;
  assign stb.take  = regRd && (addrE == ADDR_DATA);
  assign irq       = irqEnBit && (ready || seedErr || clkErr);

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      runBit <= 1'b0; irqEnBit <= 1'b0;
      seedErr <= 1'b0; clkErr <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (!runBit || beatEdge)     idleCnt <= '0;
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
      if (regWr && addrE == ADDR_CTRL) begin
        runBit   <= regWdata[0];
        irqEnBit <= regWdata[1];
      end
      if (regWr && addrE == ADDR_STAT) begin
        if (!regWdata[1]) clkErr  <= 1'b0;
        if (!regWdata[2]) seedErr <= 1'b0;
      end
      if (seedHit)                            seedErr <= 1'b1;
      if (runBit && idleCnt == IDLE_MAX)      clkErr  <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (addrE)
      ADDR_CTRL: regRdata[1:0] = {irqEnBit, runBit};
      ADDR_STAT: regRdata[2:0] = {seedErr, clkErr, ready};
      ADDR_DATA: regRdata = ready ? dataWord : '0;
      default:   regRdata = '0;
    endcase
  end

  // R8: seed error is raised only by the datapath's run detector
  a_r8_seed_source: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(seedErr) |-> $past(seedHit));

  // R9: clock error only while running and with no generator edge arriving
  a_r9_clk_err_running: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(clkErr) |-> ($past(runBit) && !$past(beatEdge)));
endmodule

// File: rtl/rng_regif.sv
module rng_regif #(
  parameter int WORD_W    = 32,
  parameter int WARM      = 4,
  parameter int SYNC      = 2,
  parameter int FILL      = 32,
  parameter int SEED_RUN  = 64,
  parameter int CLK_LIMIT = 32
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              genClk,
  input  logic              genRstN,
  input  logic              noiseIn,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq
);
  import rng_pkg::*;

  logic bitValid, bitVal, beatEdge, runBus, ready, seedHit;
  logic [WORD_W-1:0] dataWord;
  dpStrobeS stb;

  rng_sampler #(.WARM(WARM), .SYNC(SYNC)) u_sampler (
    .busClk(busClk), .busRstN(busRstN), .genClk(genClk), .genRstN(genRstN),
    .runBus(runBus), .noiseIn(noiseIn),
    .bitValid(bitValid), .bitVal(bitVal), .beatEdge(beatEdge)
  );

  rng_datapath #(.WORD_W(WORD_W), .FILL(FILL), .SEED_RUN(SEED_RUN)) u_dp (
    .busClk(busClk), .busRstN(busRstN), .bitValid(bitValid), .bitVal(bitVal),
    .stb(stb), .ready(ready), .dataWord(dataWord), .seedHit(seedHit)
  );

  rng_ctrl #(.WORD_W(WORD_W), .CLK_LIMIT(CLK_LIMIT)) u_ctrl (
    .busClk(busClk), .busRstN(busRstN), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .ready(ready), .dataWord(dataWord),
    .seedHit(seedHit), .beatEdge(beatEdge), .regRdata(regRdata), .irq(irq),
    .runOut(runBus), .stb(stb)
  );
endmodule

// File: tb/sim_rng_regif.sv
`timescale 1ns/1ps
module sim_rng_regif;
  logic busClk = 1'b0, genClk = 1'b0, genOn = 1'b1;
  logic busRstN = 1'b0, genRstN = 1'b0;
  logic noiseIn = 1'b0;
  logic [1:0] regAddr = 2'd1;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq;

  int compared = 0, mismatched = 0;
  int noiseMode = 0;           // 0: const 0, 1: const 1, 2: pseudo-random
  logic [30:0] benchLfsr = 31'h1234567;
  logic irqEnM = 1'b0;         // model of the interrupt enable bit
  bit monitorOn = 1'b0;

  rng_regif u0 (
    .busClk(busClk), .busRstN(busRstN), .genClk(genClk), .genRstN(genRstN),
    .noiseIn(noiseIn), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  always #10 busClk = ~busClk;            // 50 MHz
  always #13 if (genOn) genClk = ~genClk; // gateable generator clock

  always @(negedge genClk) begin
    benchLfsr <= {benchLfsr[29:0], benchLfsr[30] ^ benchLfsr[27]};
    case (noiseMode)
      0: noiseIn <= 1'b0;
      1: noiseIn <= 1'b1;
      default: noiseIn <= benchLfsr[0];
    endcase
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // R10 every-cycle reference: irq tracks the enable and the visible status
  always @(negedge busClk) begin
    #2;
    if (monitorOn && regAddr == 2'd1 && !regWr && !regRd)
      checkEq("R10 irq", {31'b0, irq}, {31'b0, irqEnM & (|regRdata[2:0])});
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge busClk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge busClk);
    regWr = 1'b0; regAddr = 2'd1;
    if (a == 2'd0) irqEnM = d[1];
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge busClk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge busClk);
    regRd = 1'b0; regAddr = 2'd1;
  endtask

  task automatic waitReady(input int limit, output bit found);
    found = 1'b0;
    for (int i = 0; i < limit && !found; i++) begin
      @(negedge busClk);
      #1 if (regAddr == 2'd1 && regRdata[0]) found = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  function automatic logic [31:0] modelWord(input logic b);
    logic [15:0] l = '0, p = '0;
    logic [31:0] w = '0;
    logic fb, nb, ob;
    for (int i = 0; i < 64; i++) begin
      fb = l[15] ^ l[13] ^ l[12] ^ l[10];
      nb = b ^ fb;
      ob = p[15] ^ nb;
      p  = {p[14:0], l[15]};
      l  = {l[14:0], nb};
      w  = {w[30:0], ob};
    end
    return w;
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    bit found;
    idle(5);
    busRstN = 1'b1; genRstN = 1'b1;
    idle(2);

    // R1 reset state
    regRead(2'd0, d); checkEq("R1 ctrl", d, 32'h0);
    regRead(2'd1, d); checkEq("R1 status", d, 32'h0);
    regRead(2'd2, d); checkEq("R1 data", d, 32'h0);
    checkEq("R1 irq", {31'b0, irq}, 32'h0);
    monitorOn = 1'b1;

    // R2 control read-back, generation still off
    regWrite(2'd0, 32'hFFFF_FFFE);
    regRead(2'd0, d); checkEq("R2 ctrl readback", d, 32'h2);

    // R3 / R4 / R8 / R12: constant-1 stream
    noiseMode = 1;
    regWrite(2'd0, 32'h3);
    idle(10);
    regRead(2'd1, d); checkEq("R3 no early word", d, 32'h0);
    waitReady(5000, found); checkEq("R4 word produced", {31'b0, found}, 32'h1);
    regRead(2'd1, d); checkEq("R5 R8 status ready+seed", d, 32'h5);
    checkEq("R10 irq on", {31'b0, irq}, 32'h1);
    regRead(2'd2, d); checkEq("R4 R12 word const1", d, modelWord(1'b1));

    // R6 / R7: consume then refill
    regRead(2'd1, d); checkEq("R7 ready cleared", d & 32'h1, 32'h0);
    regRead(2'd2, d); checkEq("R6 data zero when empty", d, 32'h0);
    idle(20);
    regRead(2'd1, d); checkEq("R7 no early refill", d & 32'h1, 32'h0);
    waitReady(5000, found); checkEq("R7 refill", {31'b0, found}, 32'h1);

    // R8 clear; same run of ones does not report again
    regWrite(2'd1, 32'h0);
    idle(300);
    regRead(2'd1, d); checkEq("R8 seed cleared", d & 32'h4, 32'h0);

    // R11 stop clears word and flags
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
    regRead(2'd1, d); checkEq("R11 status after stop", d, 32'h0);
    regRead(2'd2, d); checkEq("R11 data after stop", d, 32'h0);

    // R4 / R10: constant-0 stream, interrupts off
    noiseMode = 0;
    idle(20);
    regWrite(2'd0, 32'h1);
    waitReady(5000, found); checkEq("R4 word produced zeros", {31'b0, found}, 32'h1);
    regRead(2'd1, d); checkEq("R8 seed on zeros", d, 32'h5);
    checkEq("R10 irq masked", {31'b0, irq}, 32'h0);
    regRead(2'd2, d); checkEq("R4 word const0", d, modelWord(1'b0));

    // R8 negative: varying noise gives no seed error
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
    noiseMode = 2;
    idle(20);
    regWrite(2'd0, 32'h3);
    waitReady(5000, found); checkEq("R7 word on varying noise", {31'b0, found}, 32'h1);
    regRead(2'd1, d); checkEq("R8 no seed error", d, 32'h1);

    // R9 clock error while running
    genOn = 1'b0;
    idle(60);
    regRead(2'd1, d); checkEq("R9 clk err set", d & 32'h2, 32'h2);
    checkEq("R10 irq on clk err", {31'b0, irq}, 32'h1);
    genOn = 1'b1;
    idle(10);
    regWrite(2'd1, 32'h0);
    idle(100);
    regRead(2'd1, d); checkEq("R9 clk err cleared", d & 32'h2, 32'h0);

    // R9 negative: stopped clock with run off
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0);
    genOn = 1'b0;
    idle(60);
    regRead(2'd1, d); checkEq("R9 no clk err when off", d, 32'h0);
    genOn = 1'b1;
    idle(10);

    finishRun();
  end
endmodule